// File: doc/BRIEF.md
# Windowed Coincidence Detector

The detector watches eight conditioned trigger lines and raises one internal trigger channel when a chosen group of them all rise close together in time. Each line's rising edge is turned into a pulse that lasts a programmable number of clock cycles. The pulses of the lines picked by the edge mask are ANDed. A second, level-sensitive mask can also be set. It names lines that must be high at the same moment, so it can block edge coincidences while an external low-active veto is asserted.

All settings come from one configuration word, which the surrounding logic holds steady:
- bits [7:0] form the edge mask,
- bits [15:8] form the level mask,
- bits [19:16] give the window length in cycles.

If only one mask is non-zero, the unit acts as a pure edge coincidence or as a pure level coincidence. If both masks are zero, it is silent.

Top module: `wcd_coincidence`

## Requirements
- R1: A rising edge on an input, seen at clock edge P0 (low at the previous edge, high at P0), opens that input's window for W clock cycles. The window is open in the cycles after edges P0 through P0+W-1. The output follows window state with one extra register, so a lone selected input with only the edge mask set gives exactly W high cycles on `coin_out`, starting in the cycle after edge P0+1.
- R2: With the edge mask non-zero, the coincidence condition holds in a cycle only if the windows of every edge-selected input are open together in that cycle. `coin_out` reports this one cycle later. Windows that do not overlap produce no output.
- R3: With both masks non-zero, an edge coincidence reaches `coin_out` only if every level-selected input was high at the same clock edge. A low level-selected input blocks the output.
- R4: With the level mask zero and the edge mask non-zero, the unit is a pure edge coincidence. An input held high raises the output only once, for the length of its window.
- R5: With the edge mask zero and the level mask non-zero, `coin_out` is high exactly in the cycles whose second-previous clock edge saw every level-selected input high. This is a two-register latency.
- R6: A new rising edge on an input whose window is still open reloads that window to the full length W.
- R7: With both masks zero, `coin_out` stays low whatever the inputs do.
- R8: A window field of 0 gives a window of 1 cycle.
- R9: Inputs selected by neither mask have no effect on `coin_out`.
- R10: A synchronous active-high reset clears `coin_out`, the edge history and all open windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 8 | Conditioned trigger lines |
| cfg_word | input | 20 | Configuration: edge mask [7:0], level mask [15:8], window [19:16] |
| coin_out | output | 1 | Registered coincidence output |

## Verification
The bench builds the detector with its default parameters: eight inputs and a four-bit window field. With these values the full window range can be reached, from the zero-means-one corner up to fifteen cycles, and the idle gaps between scenarios stay short. The eight lanes leave room to hold some lines as level vetoes and toggle others as unselected noise while two lines form the edge pair. Edge skews of less than and equal to the window show exactly where overlap starts and ends.

// File: rtl/wcd_pkg.sv
package wcd_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_EDGE  = 2'd1,
    MODE_LEVEL = 2'd2,
    MODE_BOTH  = 2'd3
  } wcd_mode_e;

  function automatic wcd_mode_e pick_mode(input logic edge_any, input logic lvl_any);
    return wcd_mode_e'({lvl_any, edge_any});
  endfunction

endpackage

// File: rtl/wcd_stretch.sv
module wcd_stretch #(
  parameter int WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             pulse_o,
  output logic             level_o
);

  logic             prev_q;
  logic [WIN_W-1:0] cnt_q;
  logic [WIN_W-1:0] win_eff;
  logic             rise;

  assign rise    = lvl_i & ~prev_q;
  assign win_eff = (win_i == '0) ? WIN_W'(1) : win_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      if (rise)
        cnt_q <= win_eff;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - WIN_W'(1);
    end
  end

  assign pulse_o = (cnt_q != '0);
  assign level_o = prev_q;

  // R1: an edge always opens the window on the next cycle
  p_rise_opens_r1: assert property (@(posedge clk) disable iff (rst)
    (lvl_i && !prev_q) |=> pulse_o);

  // R6: an edge reloads the full length, even mid-window
  p_restart_full_r6: assert property (@(posedge clk) disable iff (rst)
    (lvl_i && !prev_q && pulse_o) |=> (cnt_q == $past(win_eff)));

endmodule

// File: rtl/wcd_combine.sv
module wcd_combine
  import wcd_pkg::*;
#(
  parameter int NUM_IN = 8
) (
  input  logic [NUM_IN-1:0] pulse_i,
  input  logic [NUM_IN-1:0] level_i,
  input  logic [NUM_IN-1:0] emask_i,
  input  logic [NUM_IN-1:0] lmask_i,
  output logic              edge_ok_o,
  output logic              level_ok_o,
  output logic              hit_o
);

  wcd_mode_e mode;

  assign edge_ok_o  = &(pulse_i | ~emask_i);
  assign level_ok_o = &(level_i | ~lmask_i);
  assign mode       = pick_mode(|emask_i, |lmask_i);

  always_comb begin
    unique case (mode)
      MODE_OFF:   hit_o = 1'b0;
      MODE_EDGE:  hit_o = edge_ok_o;
      MODE_LEVEL: hit_o = level_ok_o;
      MODE_BOTH:  hit_o = edge_ok_o & level_ok_o;
      default:    hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/wcd_coincidence.sv
module wcd_coincidence #(
  parameter int NUM_IN = 8,
  parameter int WIN_W  = 4,
  localparam int CFG_W = 2 * NUM_IN + WIN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] trig_in,
  input  logic [CFG_W-1:0]  cfg_word,
  output logic              coin_out
);

  logic [NUM_IN-1:0] emask;
  logic [NUM_IN-1:0] lmask;
  logic [WIN_W-1:0]  win;
  logic [NUM_IN-1:0] pulse;
  logic [NUM_IN-1:0] level;
  logic              edge_ok;
  logic              level_ok;
  logic              hit;
  logic              coin_q;

  assign emask = cfg_word[NUM_IN-1:0];
  assign lmask = cfg_word[2*NUM_IN-1:NUM_IN];
  assign win   = cfg_word[CFG_W-1:2*NUM_IN];

  for (genvar g = 0; g < NUM_IN; g++) begin : g_lane
    wcd_stretch #(.WIN_W(WIN_W)) u_stretch (
      .clk     (clk),
      .rst     (rst),
      .lvl_i   (trig_in[g]),
      .win_i   (win),
      .pulse_o (pulse[g]),
      .level_o (level[g])
    );
  end

  wcd_combine #(.NUM_IN(NUM_IN)) u_combine (
    .pulse_i    (pulse),
    .level_i    (level),
    .emask_i    (emask),
    .lmask_i    (lmask),
    .edge_ok_o  (edge_ok),
    .level_ok_o (level_ok),
    .hit_o      (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) coin_q <= 1'b0;
    else     coin_q <= hit;
  end

  assign coin_out = coin_q;

  // R7: no mask selected means a silent output
  p_silent_masks_r7: assert property (@(posedge clk) disable iff (rst)
    (emask == '0 && lmask == '0) |=> !coin_out);

  // R2: an edge-driven output needs all selected windows open one cycle earlier
  p_edge_overlap_r2: assert property (@(posedge clk) disable iff (rst)
    (coin_out && emask != '0 && $past(emask) == emask) |-> $past(edge_ok));

  // R3: level-selected lines must have been high
  p_level_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (coin_out && $past(lmask) == lmask) |-> $past(level_ok));

  // R10: reset leaves the output low
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> !coin_out);

endmodule

// File: tb/wcd_coincidence_bench.sv
module wcd_coincidence_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_IN = 8;
  localparam int WIN_W  = 4;
  localparam int CFG_W  = 2 * NUM_IN + WIN_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NUM_IN-1:0] trig_in = '0;
  logic [CFG_W-1:0]  cfg_word = '0;
  logic              coin_out;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wcd_coincidence #(.NUM_IN(NUM_IN), .WIN_W(WIN_W)) u_wcd_coincidence (
    .clk      (clk),
    .rst      (rst),
    .trig_in  (trig_in),
    .cfg_word (cfg_word),
    .coin_out (coin_out)
  );

  function automatic logic [CFG_W-1:0] mk(input logic [7:0] e, input logic [7:0] l,
                                          input logic [3:0] w);
    return {w, l, e};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    trig_in = '0;
    repeat (18) step();
  endtask

  task automatic count_high(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (coin_out) hits++;
    end
  endtask

  task automatic t_reset();
    check("R10 reset state", coin_out, 0);
  endtask

  task automatic t_single_window();
    int h;
    cfg_word = mk(8'h01, 8'h00, 4'd5);
    trig_in = 8'h01; step(); trig_in = 8'h00;
    check("R1 latency edge cycle", coin_out, 0);
    count_high(8, h);
    check("R1 window length 5", h, 5);
    idle();
  endtask

  task automatic t_pair_aligned();
    cfg_word = mk(8'h03, 8'h00, 4'd3);
    trig_in = 8'h03; step();
    check("R2 aligned P0", coin_out, 0);
    step(); check("R2 aligned P1", coin_out, 1);
    step(); check("R4 held P2", coin_out, 1);
    step(); check("R4 held P3", coin_out, 1);
    step(); check("R4 held high ends", coin_out, 0);
    idle();
  endtask

  task automatic t_pair_skew();
    int h;
    cfg_word = mk(8'h03, 8'h00, 4'd3);
    trig_in = 8'h01; step(); step();
    trig_in = 8'h03; step();
    check("R2 skew2 before overlap", coin_out, 0);
    step(); check("R2 skew2 overlap", coin_out, 1);
    step(); check("R2 skew2 after", coin_out, 0);
    idle();
    trig_in = 8'h01; step(); step(); step();
    trig_in = 8'h03;
    count_high(8, h);
    check("R2 skew3 no overlap", h, 0);
    idle();
  endtask

  task automatic t_level_gate();
    int h;
    cfg_word = mk(8'h01, 8'h04, 4'd3);
    trig_in = 8'h01;
    count_high(6, h);
    check("R3 veto low blocks", h, 0);
    idle();
    trig_in = 8'h04; step(); step();
    trig_in = 8'h05;
    count_high(8, h);
    check("R3 veto high passes", h, 3);
    idle();
  endtask

  task automatic t_unselected();
    int h;
    cfg_word = mk(8'h01, 8'h00, 4'd2);
    h = 0;
    for (int i = 0; i < 10; i++) begin
      trig_in = (i % 2 == 0) ? 8'hFE : 8'h00;
      step();
      if (coin_out) h++;
    end
    check("R9 unselected ignored", h, 0);
    idle();
  endtask

  task automatic t_restart();
    int h;
    cfg_word = mk(8'h01, 8'h00, 4'd2);
    trig_in = 8'h01; step();
    trig_in = 8'h00; step();
    trig_in = 8'h01; step();
    h = 0;
    step(); if (coin_out) h++;
    step(); if (coin_out) h++;
    check("R6 reload keeps window", coin_out, 1);
    step(); if (coin_out) h++;
    check("R6 reloaded window ends", coin_out, 0);
    check("R6 high count after reload", h, 2);
    idle();
  endtask

  task automatic t_zero_window();
    int h;
    cfg_word = mk(8'h01, 8'h00, 4'd0);
    trig_in = 8'h01; step(); trig_in = 8'h00;
    count_high(6, h);
    check("R8 zero window one cycle", h, 1);
    idle();
  endtask

  task automatic t_pure_level();
    cfg_word = mk(8'h00, 8'h30, 4'd0);
    trig_in = 8'h30; step();
    check("R5 level latency P0", coin_out, 0);
    step(); check("R5 level asserted", coin_out, 1);
    step(); step(); check("R5 level held", coin_out, 1);
    trig_in = 8'h10; step();
    check("R5 drop one cycle later", coin_out, 1);
    step(); check("R5 level released", coin_out, 0);
    idle();
  endtask

  task automatic t_no_masks();
    int h;
    cfg_word = mk(8'h00, 8'h00, 4'd15);
    h = 0;
    for (int i = 0; i < 10; i++) begin
      trig_in = (i % 2 == 0) ? 8'hFF : 8'h00;
      step();
      if (coin_out) h++;
    end
    check("R7 both masks zero", h, 0);
    idle();
  endtask

  task automatic t_mid_reset();
    int h;
    cfg_word = mk(8'h01, 8'h00, 4'd15);
    trig_in = 8'h01; step(); trig_in = 8'h00; step();
    rst = 1'b1; step();
    check("R10 reset clears output", coin_out, 0);
    rst = 1'b0;
    count_high(16, h);
    check("R10 reset clears windows", h, 0);
    idle();
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    t_reset();
    t_single_window();
    t_pair_aligned();
    t_pair_skew();
    t_level_gate();
    t_unselected();
    t_restart();
    t_zero_window();
    t_pure_level();
    t_no_masks();
    t_mid_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule